// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on an 8-bit parallel MPEG transport stream with a byte valid strobe. It aligns to the 188-byte packet grid by hunting for the 0x47 sync byte. It then reads the 13-bit packet identifier from each header and compares it in parallel against a programmable table of identifiers, each entry with its own enable bit. A packet that hits an enabled entry leaves on an output byte stream in one piece, marked with the index of the entry it hit. All other packets are discarded.

For each table entry the block remembers the last continuity counter it saw. When the sequence breaks, it raises a one-cycle lost-packet pulse and sets a sticky per-entry flag. The table is loaded through a plain write port. Each write replaces one entry and restarts that entry's continuity history. The output lags the input by exactly three valid bytes, which is the time needed to hold the header until the identifier is known.

Top module: `ts_pid_filter`

## Requirements
- R1: `locked` rises in the cycle after the third 0x47 byte, where the three sync bytes are each exactly 188 valid bytes apart. Lock hunting restarts at any byte that is not 0x47 in an expected sync position.
- R2: While locked, a byte other than 0x47 at an expected sync position drops `locked` in the next cycle. The packet it would have started is not forwarded.
- R3: The identifier is bits [4:0] of header byte 1 as the high part and all of header byte 2 as the low part. A locked packet whose identifier equals an enabled entry is output as all 188 of its bytes, in order. A packet with no matching entry produces no output.
- R4: Output lags input by three valid bytes. The packet's 0x47 byte appears with `out_sop` high in the cycle after the edge that accepts header byte 3. `out_valid` is high only in the cycle after an edge where `in_valid` was high.
- R5: When several enabled entries hold the same identifier, `out_chan` carries the lowest-numbered one. `out_chan` stays constant for the whole packet.
- R6: A packet with identifier 0x1FFF is never forwarded, even when an enabled entry holds 0x1FFF.
- R7: `cfg_we` stores `cfg_pid` and `cfg_en` into entry `cfg_addr`. A disabled entry never matches. A write takes effect for any packet whose header byte 2 is accepted after the write edge.
- R8: The continuity counter is the low nibble of header byte 3. For a forwarded packet whose counter is not the entry's previous counter plus one (modulo 16), `lost_pulse` is high for one cycle, `lost_chan` shows the entry, and bit `lost_chan` of `lost_sticky` is set.
- R9: A write to an entry clears that entry's sticky flag and its continuity history. The first forwarded packet on that entry after the write raises no lost-packet pulse.
- R10: No packet is forwarded before lock is reached. The packet whose sync byte completes the lock is forwarded.
- R11: After reset, `out_valid`, `out_sop`, `locked`, `lost_pulse` and `lost_sticky` are all zero, and every table entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input stream byte |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_addr | input | 6 | Entry index written |
| cfg_pid | input | 13 | Identifier stored in the entry |
| cfg_en | input | 1 | Enable bit stored in the entry |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Output stream byte |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_chan | output | 6 | Index of the entry the packet matched |
| locked | output | 1 | Packet alignment held |
| lost_pulse | output | 1 | One-cycle continuity error strobe |
| lost_chan | output | 6 | Entry that saw the continuity error |
| lost_sticky | output | 64 | Per-entry continuity error flags |

## Verification
The assertions assume that `in_byte` and the configuration inputs carry known values whenever their strobes are high, and that reset is held for at least one edge. The stimulus drives every input at the falling edge and clears `in_valid` whenever it issues a table write. Payload bytes are kept below 0x40, so a stray 0x47 cannot create a false lock while the block is hunting. The gaps in `in_valid` are random but are always inserted between whole bytes, so the three-byte lag can be checked across those gaps.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam logic [7:0]  SYNC_BYTE = 8'h47;
    localparam logic [12:0] NULL_PID  = 13'h1FFF;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_CHECK = 2'd1,
        ST_LOCK  = 2'd2
    } lock_st_e;
endpackage

// File: rtl/ts_sync_lock.sv
module ts_sync_lock
    import ts_pkg::*;
#(
    parameter int PKT_LEN  = 188,
    parameter int LOCK_CNT = 3,
    localparam int POS_W   = $clog2(PKT_LEN),
    localparam int CNT_W   = $clog2(LOCK_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             locked,
    output logic             pkt_act,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        lock_st_e         st;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic             pkt;
    } state_t;

    state_t q, d;
    logic   is_sync;
    logic   at_sync;
    logic [POS_W-1:0] pos_inc;

    always_comb begin
        d       = q;
        is_sync = (in_byte == SYNC_BYTE);
        at_sync = (q.pos == '0);
        pos_inc = (q.pos == POS_W'(PKT_LEN - 1)) ? '0 : q.pos + POS_W'(1);
        if (in_valid) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (is_sync) begin
                        d.st  = ST_CHECK;
                        d.cnt = CNT_W'(1);
                        d.pos = POS_W'(1);
                    end
                end
                ST_CHECK: begin
                    if (!at_sync) begin
                        d.pos = pos_inc;
                    end else if (is_sync) begin
                        d.pos = POS_W'(1);
                        if (q.cnt == CNT_W'(LOCK_CNT - 1)) begin
                            d.st  = ST_LOCK;
                            d.cnt = '0;
                            d.pkt = 1'b1;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end else begin
                        d.st  = ST_HUNT;
                        d.cnt = '0;
                        d.pos = '0;
                    end
                end
                default: begin
                    if (!at_sync) begin
                        d.pos = pos_inc;
                    end else if (is_sync) begin
                        d.pos = POS_W'(1);
                        d.pkt = 1'b1;
                    end else begin
                        d.st  = ST_HUNT;
                        d.pkt = 1'b0;
                        d.pos = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_HUNT, pos: '0, cnt: '0, pkt: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign locked  = (q.st == ST_LOCK);
    assign pkt_act = q.pkt;
    assign pos     = q.pos;

    // R1
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid && in_byte == SYNC_BYTE));

    // R2
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(in_valid && in_byte != SYNC_BYTE));

    // R10
    pkt_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_act |-> locked);
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match
    import ts_pkg::*;
#(
    parameter int N_ENT   = 64,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [12:0]      cfg_pid,
    input  logic             cfg_en,
    input  logic [12:0]      look_pid,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    typedef struct packed {
        logic [N_ENT-1:0][12:0] pid;
        logic [N_ENT-1:0]       en;
    } state_t;

    state_t q, d;
    logic [N_ENT-1:0] lane_eq;

    for (genvar g = 0; g < N_ENT; g++) begin : g_lane
        assign lane_eq[g] = q.en[g] && (q.pid[g] == look_pid);
    end

    always_comb begin
        d = q;
        if (cfg_we) begin
            d.pid[cfg_addr] = cfg_pid;
            d.en[cfg_addr]  = cfg_en;
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (lane_eq[i]) hit_idx = IDX_W'(i);
        end
        hit = |lane_eq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en) |=> !(hit && hit_idx == $past(cfg_addr)));

    // R7
    enabled_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_en) |=> (look_pid != $past(cfg_pid) || hit));
endmodule

// File: rtl/ts_cc_track.sv
module ts_cc_track #(
    parameter int N_ENT   = 64,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic [3:0]       chk_cc,
    input  logic             clr_we,
    input  logic [IDX_W-1:0] clr_idx,
    output logic             lost_pulse,
    output logic [IDX_W-1:0] lost_idx,
    output logic [N_ENT-1:0] sticky
);
    typedef struct packed {
        logic [N_ENT-1:0][3:0] last;
        logic [N_ENT-1:0]      seen;
        logic [N_ENT-1:0]      sticky;
        logic                  pulse;
        logic [IDX_W-1:0]      pidx;
    } state_t;

    state_t q, d;
    logic [3:0] want_cc;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        want_cc = q.last[chk_idx] + 4'd1;
        if (chk) begin
            if (q.seen[chk_idx] && chk_cc != want_cc) begin
                d.pulse           = 1'b1;
                d.pidx            = chk_idx;
                d.sticky[chk_idx] = 1'b1;
            end
            d.seen[chk_idx] = 1'b1;
            d.last[chk_idx] = chk_cc;
        end
        if (clr_we) begin
            d.seen[clr_idx]   = 1'b0;
            d.sticky[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lost_pulse = q.pulse;
    assign lost_idx   = q.pidx;
    assign sticky     = q.sticky;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |=> !lost_pulse);

    // R8
    sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sticky & ~$past(sticky))) |-> lost_pulse);
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
    import ts_pkg::*;
#(
    parameter int N_ENT    = 64,
    parameter int PKT_LEN  = 188,
    parameter int LOCK_CNT = 3,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int POS_W   = $clog2(PKT_LEN),
    localparam int HDR_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [12:0]      cfg_pid,
    input  logic             cfg_en,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sop,
    output logic [IDX_W-1:0] out_chan,
    output logic             locked,
    output logic             lost_pulse,
    output logic [IDX_W-1:0] lost_chan,
    output logic [N_ENT-1:0] lost_sticky
);
    typedef struct packed {
        logic [HDR_DLY-1:0][7:0] taps;
        logic [4:0]              pid_hi;
        logic                    fwd;
        logic [IDX_W-1:0]        chan;
        logic [POS_W-1:0]        left;
        logic                    out_valid;
        logic [7:0]              out_byte;
        logic                    out_sop;
        logic [IDX_W-1:0]        out_chan;
    } state_t;

    state_t q, d;

    logic             pkt_act;
    logic [POS_W-1:0] pos;
    logic [12:0]      look_pid;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             start;
    logic             emit;

    ts_sync_lock #(.PKT_LEN(PKT_LEN), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .locked(locked), .pkt_act(pkt_act), .pos(pos)
    );

    assign look_pid = {q.pid_hi, in_byte};

    ts_pid_match #(.N_ENT(N_ENT)) u_match (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_pid(cfg_pid), .cfg_en(cfg_en), .look_pid(look_pid),
        .hit(hit), .hit_idx(hit_idx)
    );

    assign start = in_valid && pkt_act && (pos == POS_W'(HDR_DLY)) && q.fwd;
    assign emit  = start || (q.left != '0);

    ts_cc_track #(.N_ENT(N_ENT)) u_cc (
        .clk(clk), .rst_n(rst_n), .chk(start), .chk_idx(q.chan),
        .chk_cc(in_byte[3:0]), .clr_we(cfg_we), .clr_idx(cfg_addr),
        .lost_pulse(lost_pulse), .lost_idx(lost_chan), .sticky(lost_sticky)
    );

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_sop   = 1'b0;
        if (in_valid) begin
            for (int i = HDR_DLY - 1; i > 0; i--) begin
                d.taps[i] = q.taps[i-1];
            end
            d.taps[0] = in_byte;
            if (pkt_act && pos == POS_W'(1)) begin
                d.pid_hi = in_byte[4:0];
            end
            if (pos == POS_W'(2)) begin
                d.fwd  = pkt_act && hit && (look_pid != NULL_PID);
                d.chan = hit_idx;
            end
            if (emit) begin
                d.out_valid = 1'b1;
                d.out_byte  = q.taps[HDR_DLY-1];
                d.out_sop   = start;
                if (start) begin
                    d.out_chan = q.chan;
                    d.left     = POS_W'(PKT_LEN - 1);
                end else begin
                    d.left = q.left - POS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.out_valid;
    assign out_byte  = q.out_byte;
    assign out_sop   = q.out_sop;
    assign out_chan  = q.out_chan;

    // R4
    sop_is_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_byte == SYNC_BYTE && out_valid));

    // R4
    out_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R5
    chan_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> $stable(out_chan));
endmodule

// File: tb/sim_ts_pid_filter.sv
module sim_ts_pid_filter;
    localparam int N  = 64;
    localparam int PL = 188;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [12:0] cfg_pid = '0;
    logic        cfg_en = 1'b0;
    logic        out_valid, out_sop, locked, lost_pulse;
    logic [7:0]  out_byte;
    logic [5:0]  out_chan, lost_chan;
    logic [63:0] lost_sticky;

    always #4 clk = ~clk;

    ts_pid_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_pid(cfg_pid), .cfg_en(cfg_en),
        .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
        .out_chan(out_chan), .locked(locked), .lost_pulse(lost_pulse),
        .lost_chan(lost_chan), .lost_sticky(lost_sticky)
    );

    int compared = 0;
    int mismatched = 0;
    int sop_cnt [N];
    bit gaps = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int st, cnt, pos, pkt, fwd, chan, left, pid_hi, look, fi;
    int opos, opkt, ofwd, b, start;
    int hist [3];
    int t_pid [N];
    bit t_en [N];
    bit seen [N];
    int last_cc [N];
    logic [63:0] e_sticky;
    bit e_valid, e_sop, e_lost, e_locked;
    int e_byte, e_chan, e_lchan;

    always @(posedge clk) begin
        if (!rst_n) begin
            st = 0; cnt = 0; pos = 0; pkt = 0; fwd = 0; chan = 0; left = 0; pid_hi = 0;
            for (int i = 0; i < 3; i++) hist[i] = 0;
            for (int i = 0; i < N; i++) begin
                t_pid[i] = 0; t_en[i] = 0; seen[i] = 0; last_cc[i] = 0;
            end
            e_sticky = '0; e_valid = 0; e_sop = 0; e_lost = 0; e_locked = 0;
            e_byte = 0; e_chan = 0; e_lchan = 0;
        end else begin
            e_lost = 0;
            if (in_valid) begin
                b = int'(in_byte); opos = pos; opkt = pkt; ofwd = fwd;
                if (st == 0) begin
                    if (b == 'h47) begin st = 1; cnt = 1; pos = 1; end
                end else if (pos != 0) begin
                    pos = (pos + 1) % PL;
                end else if (b == 'h47) begin
                    pos = 1;
                    if (st == 2) pkt = 1;
                    else begin
                        cnt++;
                        if (cnt == 3) begin st = 2; pkt = 1; end
                    end
                end else begin
                    st = 0; cnt = 0; pkt = 0; pos = 0;
                end
                if (opkt == 1 && opos == 1) pid_hi = b & 'h1F;
                if (opos == 2) begin
                    fwd = 0;
                    if (opkt == 1) begin
                        look = pid_hi * 256 + b;
                        fi = -1;
                        for (int i = N - 1; i >= 0; i--)
                            if (t_en[i] && t_pid[i] == look) fi = i;
                        if (fi >= 0 && look != 'h1FFF) begin fwd = 1; chan = fi; end
                    end
                end
                start = (opkt == 1 && opos == 3 && ofwd == 1) ? 1 : 0;
                if (start == 1) begin
                    if (seen[chan] && (b & 15) != (last_cc[chan] + 1) % 16) begin
                        e_lost = 1; e_lchan = chan; e_sticky[chan] = 1'b1;
                    end
                    seen[chan] = 1; last_cc[chan] = b & 15;
                end
                if (start == 1 || left > 0) begin
                    e_valid = 1; e_byte = hist[2]; e_sop = (start == 1);
                    if (start == 1) begin e_chan = chan; left = PL - 1; end
                    else left--;
                end else begin
                    e_valid = 0; e_sop = 0;
                end
                hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = b;
            end else begin
                e_valid = 0; e_sop = 0;
            end
            if (cfg_we) begin
                t_pid[cfg_addr] = int'(cfg_pid); t_en[cfg_addr] = cfg_en;
                seen[cfg_addr] = 0; e_sticky[cfg_addr] = 1'b0;
            end
            e_locked = (st == 2);
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check("R1 locked", 64'(locked), 64'(e_locked));
            check("R3 out_valid", 64'(out_valid), 64'(e_valid));
            check("R8 lost_pulse", 64'(lost_pulse), 64'(e_lost));
            check("R9 lost_sticky", lost_sticky, e_sticky);
            if (e_valid) begin
                check("R4 out_byte", 64'(out_byte), 64'(e_byte));
                check("R4 out_sop", 64'(out_sop), 64'(e_sop));
                check("R5 out_chan", 64'(out_chan), 64'(e_chan));
            end
            if (e_lost) check("R8 lost_chan", 64'(lost_chan), 64'(e_lchan));
            if (out_valid && out_sop) sop_cnt[out_chan]++;
        end
    end

    task automatic send_byte(input logic [7:0] v);
        if (gaps && ($urandom % 4) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = v;
    endtask

    task automatic send_pkt(input logic [12:0] pid, input logic [3:0] cc, input logic [7:0] sb);
        send_byte(sb);
        send_byte({3'b000, pid[12:8]});
        send_byte(pid[7:0]);
        send_byte({4'h1, cc});
        for (int i = 4; i < PL; i++) send_byte(8'((i * 13 + 5) & 8'h3F));
    endtask

    task automatic cfg_write(input int a, input logic [12:0] pid, input logic en);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_pid = pid; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) sop_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 out_valid", 64'(out_valid), 64'd0);
        check("R11 locked", 64'(locked), 64'd0);
        check("R11 lost_sticky", lost_sticky, 64'd0);

        cfg_write(5, 13'h0100, 1'b1);
        cfg_write(9, 13'h00AB, 1'b1);
        cfg_write(3, 13'h00AB, 1'b1);
        cfg_write(1, 13'h1FFF, 1'b1);
        cfg_write(7, 13'h0055, 1'b0);
        cfg_write(63, 13'h1234, 1'b1);

        // R10 / R1: lock on third packet
        send_pkt(13'h0100, 4'd0, 8'h47);
        send_pkt(13'h0100, 4'd1, 8'h47);
        check("R10 unlocked before third", 64'(locked), 64'd0);
        send_pkt(13'h0100, 4'd2, 8'h47);
        idle(1);
        check("R1 locked after third", 64'(locked), 64'd1);
        send_pkt(13'h0200, 4'd0, 8'h47);
        check("R10 one packet on entry 5", 64'(sop_cnt[5]), 64'd1);

        send_pkt(13'h00AB, 4'd0, 8'h47);
        send_pkt(13'h1FFF, 4'd0, 8'h47);
        send_pkt(13'h0055, 4'd0, 8'h47);
        send_pkt(13'h1234, 4'd5, 8'h47);
        send_pkt(13'h0100, 4'd3, 8'h47);
        send_pkt(13'h0100, 4'd5, 8'h47);
        send_pkt(13'h0200, 4'd1, 8'h47);
        check("R8 sticky entry 5", 64'(lost_sticky[5]), 64'd1);
        check("R5 lowest entry wins", 64'(sop_cnt[3]), 64'd1);
        check("R5 higher entry unused", 64'(sop_cnt[9]), 64'd0);
        check("R6 null dropped", 64'(sop_cnt[1]), 64'd0);
        check("R7 disabled dropped", 64'(sop_cnt[7]), 64'd0);
        check("R3 entry 63 forwarded", 64'(sop_cnt[63]), 64'd1);
        check("R3 entry 5 count", 64'(sop_cnt[5]), 64'd3);

        cfg_write(5, 13'h0100, 1'b1);
        @(negedge clk);
        check("R9 sticky cleared", 64'(lost_sticky[5]), 64'd0);
        gaps = 1;
        send_pkt(13'h0100, 4'd9, 8'h47);
        send_pkt(13'h0100, 4'd10, 8'h47);
        check("R9 no error after write", 64'(lost_sticky[5]), 64'd0);

        cfg_write(7, 13'h0055, 1'b1);
        send_pkt(13'h0055, 4'd0, 8'h47);
        send_pkt(13'h0200, 4'd2, 8'h47);
        check("R7 enabled entry forwards", 64'(sop_cnt[7]), 64'd1);

        // R2 lock loss
        send_pkt(13'h0100, 4'd11, 8'h00);
        idle(2);
        check("R2 lock dropped", 64'(locked), 64'd0);
        check("R2 packet not forwarded", 64'(sop_cnt[5]), 64'd5);

        send_pkt(13'h00AB, 4'd1, 8'h47);
        send_pkt(13'h00AB, 4'd2, 8'h47);
        send_pkt(13'h00AB, 4'd3, 8'h47);
        send_pkt(13'h00AB, 4'd5, 8'h47);
        send_pkt(13'h1234, 4'd6, 8'h47);
        for (int i = 0; i < 4; i++) send_byte(8'h00);
        idle(10);
        check("R3 relock forwards", 64'(sop_cnt[3]), 64'd3);
        finish_run();
    end
endmodule